// File: doc/BRIEF.md
# PCI Interrupt Line Steering Router

This block takes the four shared PCI interrupt request lines (A to D) and steers each one onto one of sixteen level-sensitive inputs of a legacy interrupt controller. Software chooses the destination of each request line by writing one routing byte per line through a byte-wide configuration port. A routing byte that names an output from 0 to 15 connects the line to that output. A routing byte of 16 or more disconnects the line.

Each output is the wired-OR of every request line currently routed to it. The block keeps a registered level map with one bit per (output, request line) pair. Every cycle it rebuilds the whole map from the present routing bytes and request levels, so rerouting never leaves a stale level behind. The package also provides a helper function that turns a device/function number and an interrupt pin into the request line the device drives. The pins rotate by slot across the four lines.

Top module: `irq_steer_router`

## Requirements
- R1: While reset is asserted (synchronous, active low), all four routing bytes are set to 0x80, the level map is cleared, and after the reset edge all sixteen outputs are low.
- R2: The routing bytes for request lines A, B, C and D sit at configuration addresses 0x60, 0x61, 0x62 and 0x63, in that order. A write with `cfg_wr_en` high stores `cfg_wr_data` on the rising edge. A read is combinational on `cfg_addr` and returns the last written byte unchanged, including values of 16 and above.
- R3: A write to any address outside 0x60..0x63 changes no routing byte. A read of such an address returns 0x00.
- R4: A routing byte with value v below 16 steers its request line to output `irq_out[v]`.
- R5: A routing byte of 16 or greater disables its request line: that line drives no output whatever its level.
- R6: Each output is high exactly when at least one request line routed to it is high. Several lines routed to one output combine as a logical OR.
- R7: A change on `req_lvl` appears on `irq_out` after the next rising clock edge, and not before.
- R8: A routing write takes effect on the outputs at the second rising edge after the write is sampled. At that edge the old destination of a still-asserted line goes low and the new destination goes high. No level from the old routing is kept.
- R9: The helper `slot_pin_to_line` returns request line (pin + (devfn >> 3) − 1) mod 4. Here pin is 0..3 for INTA..INTD and devfn is the 8-bit device/function number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 8 | Configuration byte address for read and write |
| cfg_wr_en | input | 1 | Write strobe for the configuration port |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_data | output | 8 | Combinational read data for `cfg_addr` |
| req_lvl | input | 4 | Levels of request lines A (bit 0) to D (bit 3) |
| irq_out | output | 16 | Level-sensitive outputs to the interrupt controller |

## Verification
The hardest case to reach from the ports is rerouting a request line while it is held asserted. In that case the old output must fall in the same cycle the new one rises, with no stale level left in the map. The stimulus holds one line high, parks it on one output, and rewrites its routing byte. It then samples the outputs between the write edge and the rebuild edge, and again after the rebuild. Beyond that, a sweep walks many routing configurations, including disable values and several lines sharing one output, and applies all sixteen request patterns to each. The expected outputs are computed arithmetically.

// File: rtl/irq_steer_pkg.sv
// Shared constants and the slot/pin swizzle helper for the interrupt
// steering router. Assumes four request lines and an 8-bit devfn.
package irq_steer_pkg;

    localparam int          NUM_REQ_DEF    = 4;
    localparam int          NUM_OUT_DEF    = 16;
    localparam int          DATA_W_DEF     = 8;
    localparam int          ADDR_W_DEF     = 8;
    localparam logic [7:0]  ROUTE_BASE_DEF = 8'h60;
    localparam logic [7:0]  ROUTE_RST_DEF  = 8'h80;

    // Rotate a device's pin onto a request line: (pin + slot - 1) mod 4.
    function automatic logic [1:0] slot_pin_to_line(input logic [7:0] devfn,
                                                    input logic [1:0] pin);
        logic [5:0] sum;
        sum = {1'b0, devfn[7:3]} + {4'b0, pin} + 6'd3;
        return sum[1:0];
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
// Routing byte register file: one byte per request line at consecutive
// addresses from ROUTE_BASE. Assumes ROUTE_BASE + NUM_REQ fits in ADDR_W.
module irq_route_regs #(
    parameter int               NUM_REQ    = 4,
    parameter int               DATA_W     = 8,
    parameter int               ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60,
    parameter logic [DATA_W-1:0] RESET_VAL  = 8'h80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic                      cfg_wr_en,
    input  logic [DATA_W-1:0]         cfg_wr_data,
    output logic [DATA_W-1:0]         cfg_rd_data,
    output logic [NUM_REQ*DATA_W-1:0] route_flat
);

    logic [NUM_REQ-1:0] hit;

    // Address decode, one comparator per routing byte.
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_dec
        assign hit[r] = (cfg_addr == ADDR_W'(ROUTE_BASE + ADDR_W'(r)));
    end

    // Routing byte storage with reset to the disable value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REQ; r++)
                route_flat[r*DATA_W +: DATA_W] <= RESET_VAL;
        end else begin
            for (int r = 0; r < NUM_REQ; r++)
                if (cfg_wr_en && hit[r])
                    route_flat[r*DATA_W +: DATA_W] <= cfg_wr_data;
        end
    end

    // Read mux; addresses outside the window return zero.
    always_comb begin
        cfg_rd_data = '0;
        for (int r = 0; r < NUM_REQ; r++)
            if (hit[r]) cfg_rd_data = route_flat[r*DATA_W +: DATA_W];
    end

    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> (route_flat == {NUM_REQ{RESET_VAL}}));

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_chk
        a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_en && hit[r]) |=> (route_flat[r*DATA_W +: DATA_W] == $past(cfg_wr_data)));
    end

    a_r3_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && (hit == '0)) |=> $stable(route_flat));

endmodule

// File: rtl/irq_level_map.sv
// Registered level map: bit (o*NUM_REQ + r) is high when request line r is
// high and routed to output o. Rebuilt in full every cycle from the current
// routing bytes, so a routing change leaves no stale bits.
module irq_level_map #(
    parameter int NUM_REQ = 4,
    parameter int NUM_OUT = 16,
    parameter int DATA_W  = 8,
    localparam int MAP_W  = NUM_REQ * NUM_OUT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ*DATA_W-1:0] route_flat,
    input  logic [NUM_REQ-1:0]        req_lvl,
    output logic [MAP_W-1:0]          map_q
);

    logic [NUM_REQ-1:0] line_on;
    logic [MAP_W-1:0]   map_next;

    // A routing byte at or above NUM_OUT disables its line.
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_en
        assign line_on[r] = (route_flat[r*DATA_W +: DATA_W] < DATA_W'(NUM_OUT)) && req_lvl[r];
    end

    // One decoded bit per (output, line) pair.
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_o
        for (genvar r = 0; r < NUM_REQ; r++) begin : g_r
            assign map_next[o*NUM_REQ + r] =
                line_on[r] && (route_flat[r*DATA_W +: DATA_W] == DATA_W'(o));
        end
    end

    // Map register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_next;
    end

    a_r1_map_cleared: assert property (@(posedge clk)
        !rst_n |=> (map_q == '0));

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_chk
        logic [NUM_OUT-1:0] col;
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_col
            assign col[o] = map_q[o*NUM_REQ + r];
        end
        a_r5_disabled_column: assert property (@(posedge clk) disable iff (!rst_n)
            (route_flat[r*DATA_W +: DATA_W] >= DATA_W'(NUM_OUT)) |=> (col == '0));
    end

endmodule

// File: rtl/irq_out_combine.sv
// Wired-OR of the level map: each output is the OR of its NUM_REQ bits.
// Assumes the map is already registered, so outputs come from flops.
module irq_out_combine #(
    parameter int NUM_REQ = 4,
    parameter int NUM_OUT = 16,
    localparam int MAP_W  = NUM_REQ * NUM_OUT
) (
    input  logic [MAP_W-1:0]   map_q,
    output logic [NUM_OUT-1:0] irq_out
);

    // Reduce each output's slice of the map.
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_or
        assign irq_out[o] = |map_q[o*NUM_REQ +: NUM_REQ];
    end

endmodule

// File: rtl/irq_steer_router.sv
// Top of the PCI interrupt line steering router: routing registers, level
// map and output OR. Assumes request levels are synchronous to clk.
module irq_steer_router #(
    parameter int               NUM_REQ    = 4,
    parameter int               NUM_OUT    = 16,
    parameter int               DATA_W     = 8,
    parameter int               ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60,
    parameter logic [DATA_W-1:0] RESET_VAL  = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic               cfg_wr_en,
    input  logic [DATA_W-1:0]  cfg_wr_data,
    output logic [DATA_W-1:0]  cfg_rd_data,
    input  logic [NUM_REQ-1:0] req_lvl,
    output logic [NUM_OUT-1:0] irq_out
);

    localparam int MAP_W = NUM_REQ * NUM_OUT;

    logic [NUM_REQ*DATA_W-1:0] route_flat;
    logic [MAP_W-1:0]          map_q;

    irq_route_regs #(
        .NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .ROUTE_BASE(ROUTE_BASE), .RESET_VAL(RESET_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data), .route_flat(route_flat)
    );

    irq_level_map #(.NUM_REQ(NUM_REQ), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_map (
        .clk(clk), .rst_n(rst_n), .route_flat(route_flat), .req_lvl(req_lvl), .map_q(map_q)
    );

    irq_out_combine #(.NUM_REQ(NUM_REQ), .NUM_OUT(NUM_OUT)) u_or (
        .map_q(map_q), .irq_out(irq_out)
    );

    a_r1_outputs_low: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));

    a_r7_output_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> $past(req_lvl != '0));

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_r
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_o
            a_r6_routed_request_raises: assert property (@(posedge clk) disable iff (!rst_n)
                (req_lvl[r] && (route_flat[r*DATA_W +: DATA_W] == DATA_W'(o))) |=> irq_out[o]);
        end
    end

endmodule

// File: tb/irq_steer_router_bench.sv
module irq_steer_router_bench;
    import irq_steer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_data = 8'h00;
    logic [7:0]  cfg_rd_data;
    logic [3:0]  req_lvl = 4'h0;
    logic [15:0] irq_out;

    int n_vec = 0;
    int n_bad = 0;
    int route_m [4];

    always #4 clk = ~clk;  // 125 MHz

    irq_steer_router u_irq_steer_router (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .req_lvl(req_lvl), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wr_data = d; cfg_wr_en = 1'b1;
        tick();
        cfg_wr_en = 1'b0;
        if (a >= 8'h60 && a <= 8'h63) route_m[a - 8'h60] = int'(d);
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rd_data;
    endtask

    function automatic logic [15:0] model(input logic [3:0] req);
        logic [15:0] m = '0;
        for (int r = 0; r < 4; r++)
            if (req[r] && route_m[r] < 16) m[route_m[r]] = 1'b1;
        return m;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] rd;
        for (int r = 0; r < 4; r++) route_m[r] = 8'h80;
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values and quiet outputs
        for (int r = 0; r < 4; r++) begin
            cfg_read(8'(8'h60 + r), rd);
            check(rd == 8'h80, "R1 reset routing byte", rd, 8'h80);
        end
        req_lvl = 4'hF;
        tick();
        check(irq_out == 16'h0, "R1/R5 outputs low with all lines disabled", irq_out, 0);
        req_lvl = 4'h0;

        // R2: every byte value read back unchanged on every line
        for (int r = 0; r < 4; r++)
            for (int v = 0; v < 256; v++) begin
                cfg_write(8'(8'h60 + r), 8'(v));
                cfg_read(8'(8'h60 + r), rd);
                check(rd == 8'(v), "R2 readback", rd, v);
            end

        // R3: writes outside the window are ignored, reads give zero
        for (int r = 0; r < 4; r++) cfg_write(8'(8'h60 + r), 8'(r + 1));
        for (int a = 0; a < 256; a++) begin
            if (a >= 8'h60 && a <= 8'h63) continue;
            cfg_addr = 8'(a); cfg_wr_data = 8'h0A; cfg_wr_en = 1'b1;
            tick();
            cfg_wr_en = 1'b0;
            cfg_read(8'(a), rd);
            check(rd == 8'h00, "R3 outside read zero", rd, 0);
        end
        for (int r = 0; r < 4; r++) begin
            cfg_read(8'(8'h60 + r), rd);
            check(rd == 8'(r + 1), "R3 routing byte untouched", rd, r + 1);
        end

        // R4 R5 R6: sweep routing configurations and all request patterns
        for (int c = 0; c < 240; c++) begin
            for (int r = 0; r < 4; r++) begin
                int v;
                v = (c * (2 * r + 3) + 5 * r) % 21;
                if (v == 20) v = 255;
                cfg_write(8'(8'h60 + r), 8'(v));
            end
            for (int p = 0; p < 16; p++) begin
                req_lvl = 4'(p);
                tick();
                check(irq_out == model(4'(p)), "R4/R5/R6 steered OR", irq_out, model(4'(p)));
            end
        end

        // R6: all four lines on one output
        for (int r = 0; r < 4; r++) cfg_write(8'(8'h60 + r), 8'd7);
        for (int p = 0; p < 16; p++) begin
            req_lvl = 4'(p);
            tick();
            check(irq_out == ((p != 0) ? 16'h0080 : 16'h0), "R6 shared output OR",
                  irq_out, (p != 0) ? 16'h0080 : 16'h0);
        end

        // R7: one-edge latency from request to output
        cfg_write(8'h60, 8'd5);
        cfg_write(8'h61, 8'h90);
        cfg_write(8'h62, 8'h90);
        cfg_write(8'h63, 8'h90);
        req_lvl = 4'h0;
        tick();
        req_lvl = 4'h1;
        #1;
        check(irq_out == 16'h0, "R7 no change before edge", irq_out, 0);
        tick();
        check(irq_out == 16'h0020, "R7 change after edge", irq_out, 16'h0020);
        req_lvl = 4'h0;
        tick();
        check(irq_out == 16'h0, "R7 release after edge", irq_out, 0);

        // R8: reroute a held line; old output falls as new rises
        req_lvl = 4'h1;
        cfg_write(8'h60, 8'd3);
        tick();
        check(irq_out == 16'h0008, "R8 initial route", irq_out, 16'h0008);
        cfg_write(8'h60, 8'd9);
        check(irq_out == 16'h0008, "R8 old route until rebuild", irq_out, 16'h0008);
        tick();
        check(irq_out == 16'h0200, "R8 new route, no stale bit", irq_out, 16'h0200);
        cfg_write(8'h60, 8'd16);
        tick();
        check(irq_out == 16'h0, "R8/R5 reroute to disable", irq_out, 0);

        // R9: swizzle helper drives requests, identity routing
        for (int r = 0; r < 4; r++) cfg_write(8'(8'h60 + r), 8'(r));
        for (int s = 0; s < 32; s++)
            for (int p = 0; p < 4; p++) begin
                int exp_line;
                logic [1:0] ln;
                exp_line = ((s * 8) / 8 + p + 3) % 4;
                ln = slot_pin_to_line(8'(s * 8), 2'(p));
                check(int'(ln) == exp_line, "R9 swizzle helper", ln, exp_line);
                req_lvl = 4'(1 << ln);
                tick();
                check(irq_out == 16'(1 << exp_line), "R9 device request steered",
                      irq_out, 16'(1 << exp_line));
            end
        req_lvl = 4'h0;

        // R1: reset in mid-operation clears outputs and routing
        req_lvl = 4'hF;
        tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check(irq_out == 16'h0, "R1 outputs low after reset", irq_out, 0);
        cfg_read(8'h62, rd);
        check(rd == 8'h80, "R1 routing byte after reset", rd, 8'h80);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule